// File: doc/BRIEF.md
# Integer Multiply-Divide Execution Unit

This unit performs 32-bit integer multiplication and division for a processor core and decides on its own when the issue stage may hand it more work. Multiplies flow through a short pipeline that can take one new operation every clock. Divides use a single iterative engine that handles one operation at a time and holds the unit until its result has left. The arithmetic/logic path of the core is a separate unit and is not connected here. The stall output is driven only by multiply/divide traffic, so a cycle that issues to that path never sees a stall from this block.

The issue side is a valid/ready handshake. An operation is taken on a rising edge where `iss_valid` and `iss_ready` are both high. `iss_ready` depends on the unit's state and on the class of the presented opcode, never on `iss_valid`. `iss_stall` reports a presented operation that is being held. The result side is also a valid/ready handshake. While `res_valid` is high and `res_ready` is low, the result, its tag and its flag stay frozen. The multiply pipeline backs up behind a refused result, and a held result in turn lowers `iss_ready` for multiplies once the pipeline is full.

Opcode encoding on `iss_op`: `2'b00` signed multiply, `2'b01` unsigned multiply, `2'b10` signed divide, `2'b11` unsigned divide. Bit 1 set marks a divide.

Top module: `muldiv_unit`

## Requirements
- R1: When no divide is in the unit and `res_ready` stays high, a multiply is accepted in every cycle it is presented, so back-to-back multiplies never stall.
- R2: A multiply (opcode 00 or 01) returns the low 32 bits of `a*b`, which are the same for both opcodes. The result is presented three cycles after the acceptance cycle when the output is not held.
- R3: A divide returns the quotient rounded toward zero. Opcode 10 treats the operands as two's complement and opcode 11 as unsigned. The result is presented 34 cycles after the acceptance cycle: one setup cycle, then 32 iterations.
- R4: A divide is not accepted while any multiply remains in the pipeline. It is accepted in the first cycle the pipeline is empty and no divide is present.
- R5: From the acceptance of a divide until its result is handed over, any multiply or divide presented is held with `iss_stall` high.
- R6: `iss_stall` is high exactly when `iss_valid` is high and `iss_ready` is low. It is never high in a cycle with no operation presented.
- R7: A divide by a zero divisor completes with the normal latency, returns a result of zero, and raises `res_dz` together with that result.
- R8: `dz_flag` is set in the cycle after a divide-by-zero result is first presented and stays set until reset.
- R9: Every accepted operation produces exactly one result carrying its own `iss_tag`, and results leave in acceptance order.
- R10: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_data`, `res_tag` and `res_dz` hold their values.
- R11: After reset, `res_valid` and `dz_flag` are low and the unit is ready for either operation class.
- R12: The signed divide of 0x80000000 by 0xFFFFFFFF returns 0x80000000 and does not flag an error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | Issue stage presents an operation |
| iss_op | input | 2 | Operation code (see encoding above) |
| iss_a | input | 32 | First operand (multiplicand or dividend) |
| iss_b | input | 32 | Second operand (multiplier or divisor) |
| iss_tag | input | 5 | Destination tag carried to the result |
| iss_ready | output | 1 | Unit can take the presented operation class this cycle |
| iss_stall | output | 1 | Presented operation is being held |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_data | output | 32 | Product low word or quotient |
| res_tag | output | 5 | Tag of the operation that produced the result |
| res_dz | output | 1 | Result came from a divide by zero |
| dz_flag | output | 1 | Sticky divide-by-zero indicator |

## Verification
The bench targets the interlock edges. It checks a divide presented right behind a multiply, which must wait exactly until the pipeline drains. It checks a multiply presented right behind a divide, which must wait the full 34 cycles. A unit that released either too early would reorder or overwrite results, and one that released too late would show a wrong stall count. Arithmetic corners are division by zero, which must neither hang nor return the iteration's all-ones pattern, and the most-negative value divided by minus one, which must wrap rather than saturate. Random output back-pressure mixed with random opcodes catches a pipeline that drops, duplicates or reorders tagged results when held.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  localparam logic [1:0] OPC_MUL_S = 2'b00;
  localparam logic [1:0] OPC_MUL_U = 2'b01;
  localparam logic [1:0] OPC_DIV_S = 2'b10;
  localparam logic [1:0] OPC_DIV_U = 2'b11;

  typedef enum logic [1:0] {
    DV_IDLE  = 2'd0,
    DV_SETUP = 2'd1,
    DV_RUN   = 2'd2,
    DV_DONE  = 2'd3
  } div_state_e;

  function automatic logic opc_is_div(input logic [1:0] opc);
    return opc[1];
  endfunction

  function automatic logic opc_is_signed(input logic [1:0] opc);
    return ~opc[0];
  endfunction

endpackage

// File: rtl/muldiv_issue.sv
module muldiv_issue
  import muldiv_pkg::*;
(
  input  logic       iss_valid,
  input  logic [1:0] iss_op,
  input  logic       div_idle,
  input  logic       mul_empty,
  input  logic       mul_can_take,
  output logic       iss_ready,
  output logic       iss_stall,
  output logic       mul_push,
  output logic       div_start
);

  logic is_div;
  logic fire;

  always_comb begin
    is_div = opc_is_div(iss_op);
    // A divide needs the whole unit; a multiply only needs the divider idle
    // and room at the head of the pipeline.
    if (!div_idle)   iss_ready = 1'b0;
    else if (is_div) iss_ready = mul_empty;
    else             iss_ready = mul_can_take;
    iss_stall = iss_valid & ~iss_ready;
    fire      = iss_valid & iss_ready;
    mul_push  = fire & ~is_div;
    div_start = fire & is_div;
  end

endmodule

// File: rtl/muldiv_mulpipe.sv
module muldiv_mulpipe #(
  parameter int XLEN   = 32,
  parameter int TAG_W  = 5,
  parameter int STAGES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_push,
  input  logic [XLEN-1:0]  in_a,
  input  logic [XLEN-1:0]  in_b,
  input  logic [TAG_W-1:0] in_tag,
  output logic             in_room,
  output logic             out_valid,
  input  logic             out_take,
  output logic [XLEN-1:0]  out_data,
  output logic [TAG_W-1:0] out_tag,
  output logic             empty
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] vld;
  logic [STAGES-1:0] load;
  logic [XLEN-1:0]   dat [STAGES];
  logic [TAG_W-1:0]  tg  [STAGES];
  logic [XLEN-1:0]   opb;

  // A stage may load when it is empty or its content moves on this cycle.
  assign load[LAST] = ~vld[LAST] | out_take;
  generate
    for (genvar s = 0; s < LAST; s++) begin : g_load
      assign load[s] = ~vld[s] | load[s+1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
    end else begin
      if (load[0]) vld[0] <= in_push;
      for (int s = 1; s < STAGES; s++) begin
        if (load[s]) vld[s] <= vld[s-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (load[0]) begin
      dat[0] <= in_a;
      opb    <= in_b;
      tg[0]  <= in_tag;
    end
    if (load[1]) begin
      dat[1] <= dat[0] * opb;
      tg[1]  <= tg[0];
    end
    for (int s = 2; s < STAGES; s++) begin
      if (load[s]) begin
        dat[s] <= dat[s-1];
        tg[s]  <= tg[s-1];
      end
    end
  end

  assign in_room   = load[0];
  assign out_valid = vld[LAST];
  assign out_data  = dat[LAST];
  assign out_tag   = tg[LAST];
  assign empty     = ~|vld;

endmodule

// File: rtl/muldiv_divider.sv
module muldiv_divider
  import muldiv_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_signed,
  input  logic [XLEN-1:0]  dividend,
  input  logic [XLEN-1:0]  divisor,
  input  logic [TAG_W-1:0] tag_in,
  input  logic             take,
  output logic             idle,
  output logic             done,
  output logic [XLEN-1:0]  quotient,
  output logic [TAG_W-1:0] tag_out,
  output logic             by_zero
);

  localparam int CNT_W = $clog2(XLEN);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(XLEN - 1);

  div_state_e       st;
  logic [XLEN-1:0]  q_r;
  logic [XLEN-1:0]  d_r;
  logic [XLEN-1:0]  rem_r;
  logic [CNT_W-1:0] step;
  logic             sgn_r;
  logic             neg_r;
  logic             zero_r;
  logic [TAG_W-1:0] tag_r;
  logic [XLEN:0]    shifted;
  logic [XLEN:0]    trial;

  assign shifted = {rem_r, q_r[XLEN-1]};
  assign trial   = shifted - {1'b0, d_r};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= DV_IDLE;
      q_r    <= '0;
      d_r    <= '0;
      rem_r  <= '0;
      step   <= '0;
      sgn_r  <= 1'b0;
      neg_r  <= 1'b0;
      zero_r <= 1'b0;
      tag_r  <= '0;
    end else begin
      unique case (st)
        DV_IDLE: begin
          if (start) begin
            q_r   <= dividend;
            d_r   <= divisor;
            sgn_r <= is_signed;
            tag_r <= tag_in;
            st    <= DV_SETUP;
          end
        end
        DV_SETUP: begin
          // Convert to magnitudes and remember the quotient sign.
          neg_r  <= sgn_r & (q_r[XLEN-1] ^ d_r[XLEN-1]);
          q_r    <= (sgn_r & q_r[XLEN-1]) ? -q_r : q_r;
          d_r    <= (sgn_r & d_r[XLEN-1]) ? -d_r : d_r;
          zero_r <= (d_r == '0);
          rem_r  <= '0;
          step   <= '0;
          st     <= DV_RUN;
        end
        DV_RUN: begin
          if (!trial[XLEN]) begin
            rem_r <= trial[XLEN-1:0];
            q_r   <= {q_r[XLEN-2:0], 1'b1};
          end else begin
            rem_r <= shifted[XLEN-1:0];
            q_r   <= {q_r[XLEN-2:0], 1'b0};
          end
          step <= step + 1'b1;
          if (step == LAST_STEP) st <= DV_DONE;
        end
        DV_DONE: begin
          if (take) st <= DV_IDLE;
        end
        default: st <= DV_IDLE;
      endcase
    end
  end

  assign idle     = (st == DV_IDLE);
  assign done     = (st == DV_DONE);
  assign by_zero  = zero_r;
  assign tag_out  = tag_r;
  assign quotient = zero_r ? '0 : (neg_r ? -q_r : q_r);

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import muldiv_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int TAG_W      = 5,
  parameter int MUL_STAGES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  logic [1:0]       iss_op,
  input  logic [XLEN-1:0]  iss_a,
  input  logic [XLEN-1:0]  iss_b,
  input  logic [TAG_W-1:0] iss_tag,
  output logic             iss_ready,
  output logic             iss_stall,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [XLEN-1:0]  res_data,
  output logic [TAG_W-1:0] res_tag,
  output logic             res_dz,
  output logic             dz_flag
);

  logic             div_idle;
  logic             div_done;
  logic             div_zero;
  logic [XLEN-1:0]  div_q;
  logic [TAG_W-1:0] div_tag;
  logic             div_start;
  logic             div_take;
  logic             mul_empty;
  logic             mul_room;
  logic             mul_push;
  logic             mul_out_valid;
  logic             mul_take;
  logic [XLEN-1:0]  mul_data;
  logic [TAG_W-1:0] mul_tag;

  muldiv_issue u_issue (
    .iss_valid    (iss_valid),
    .iss_op       (iss_op),
    .div_idle     (div_idle),
    .mul_empty    (mul_empty),
    .mul_can_take (mul_room),
    .iss_ready    (iss_ready),
    .iss_stall    (iss_stall),
    .mul_push     (mul_push),
    .div_start    (div_start)
  );

  muldiv_mulpipe #(
    .XLEN   (XLEN),
    .TAG_W  (TAG_W),
    .STAGES (MUL_STAGES)
  ) u_mul (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_push   (mul_push),
    .in_a      (iss_a),
    .in_b      (iss_b),
    .in_tag    (iss_tag),
    .in_room   (mul_room),
    .out_valid (mul_out_valid),
    .out_take  (mul_take),
    .out_data  (mul_data),
    .out_tag   (mul_tag),
    .empty     (mul_empty)
  );

  muldiv_divider #(
    .XLEN  (XLEN),
    .TAG_W (TAG_W)
  ) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (div_start),
    .is_signed (opc_is_signed(iss_op)),
    .dividend  (iss_a),
    .divisor   (iss_b),
    .tag_in    (iss_tag),
    .take      (div_take),
    .idle      (div_idle),
    .done      (div_done),
    .quotient  (div_q),
    .tag_out   (div_tag),
    .by_zero   (div_zero)
  );

  // Output selection: a finished divide wins; the multiply stage waits.
  always_comb begin
    res_valid = div_done | mul_out_valid;
    div_take  = div_done & res_ready;
    mul_take  = mul_out_valid & ~div_done & res_ready;
    if (div_done) begin
      res_data = div_q;
      res_tag  = div_tag;
      res_dz   = div_zero;
    end else begin
      res_data = mul_data;
      res_tag  = mul_tag;
      res_dz   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    dz_flag <= 1'b0;
    else if (div_done && div_zero) dz_flag <= 1'b1;
  end

endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
  parameter int XLEN  = 32,
  parameter int TAG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_valid,
  input logic [1:0]       iss_op,
  input logic             iss_ready,
  input logic             iss_stall,
  input logic             res_valid,
  input logic             res_ready,
  input logic [XLEN-1:0]  res_data,
  input logic [TAG_W-1:0] res_tag,
  input logic             res_dz,
  input logic             dz_flag,
  input logic             div_idle,
  input logic             mul_empty
);

  p_stall_only_presented_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_valid |-> !iss_stall);

  p_div_waits_mul_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_op[1] && !mul_empty) |-> !iss_ready);

  p_div_free_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_op[1] && div_idle && mul_empty) |-> iss_ready);

  p_div_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !div_idle) |-> iss_stall);

  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_data) && $stable(res_tag) && $stable(res_dz)));

  p_dz_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_dz) |-> (res_data == '0));

  p_dz_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_dz) |=> dz_flag);

  p_dz_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dz_flag |=> dz_flag);

endmodule

bind muldiv_unit muldiv_unit_chk #(
  .XLEN  (XLEN),
  .TAG_W (TAG_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iss_valid (iss_valid),
  .iss_op    (iss_op),
  .iss_ready (iss_ready),
  .iss_stall (iss_stall),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_data  (res_data),
  .res_tag   (res_tag),
  .res_dz    (res_dz),
  .dz_flag   (dz_flag),
  .div_idle  (div_idle),
  .mul_empty (mul_empty)
);

// File: tb/test_muldiv_unit.sv
module test_muldiv_unit;

  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int TAG_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             iss_valid = 1'b0;
  logic [1:0]       iss_op = 2'b00;
  logic [XLEN-1:0]  iss_a = '0;
  logic [XLEN-1:0]  iss_b = '0;
  logic [TAG_W-1:0] iss_tag = '0;
  logic             iss_ready;
  logic             iss_stall;
  logic             res_valid;
  logic             res_ready = 1'b1;
  logic [XLEN-1:0]  res_data;
  logic [TAG_W-1:0] res_tag;
  logic             res_dz;
  logic             dz_flag;

  typedef struct {
    logic [TAG_W-1:0] tag;
    logic [XLEN-1:0]  data;
    logic             dz;
    logic             is_div;
    int               acc;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  bit   lat_mode = 1'b1;
  bit   bp_mode = 1'b0;
  bit   done_flag = 1'b0;
  logic [TAG_W-1:0] next_tag = '0;

  muldiv_unit i_muldiv_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .iss_valid (iss_valid),
    .iss_op    (iss_op),
    .iss_a     (iss_a),
    .iss_b     (iss_b),
    .iss_tag   (iss_tag),
    .iss_ready (iss_ready),
    .iss_stall (iss_stall),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_data  (res_data),
    .res_tag   (res_tag),
    .res_dz    (res_dz),
    .dz_flag   (dz_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [31:0] model(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb;
    logic [31:0] r;
    if (!op[1]) begin
      r = a * b;
    end else if (b == 0) begin
      r = '0;
    end else if (!op[0]) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      r  = 32'(sa / sb);
    end else begin
      r = a / b;
    end
    return r;
  endfunction

  function automatic logic [31:0] pick();
    case ($urandom % 8)
      0: return 32'h0;
      1: return 32'h1;
      2: return 32'hFFFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'h7FFF_FFFF;
      default: return $urandom;
    endcase
  endfunction

  // Present one operation; returns the number of cycles it was held.
  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b, output int stalls);
    exp_t e;
    stalls = 0;
    @(negedge clk);
    iss_valid = 1'b1;
    iss_op    = op;
    iss_a     = a;
    iss_b     = b;
    iss_tag   = next_tag;
    forever begin
      #1;
      if (iss_ready) break;
      chk(iss_stall == 1'b1, "R6", {31'b0, iss_stall}, 32'd1);
      stalls++;
      @(negedge clk);
    end
    e.tag    = next_tag;
    e.data   = model(op, a, b);
    e.dz     = op[1] && (b == 0);
    e.is_div = op[1];
    e.acc    = cyc;
    q.push_back(e);
    next_tag = next_tag + 1'b1;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    iss_valid = 1'b0;
    for (int k = 1; k < n; k++) @(negedge clk);
  endtask

  // Output consumer
  initial begin
    forever begin
      @(negedge clk);
      res_ready = bp_mode ? (($urandom % 4) != 0) : 1'b1;
    end
  end

  // Result monitor
  initial begin
    bit held = 1'b0;
    logic [31:0] h_data = '0;
    logic [TAG_W-1:0] h_tag = '0;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (!iss_valid) chk(!iss_stall, "R6", {31'b0, iss_stall}, 32'd0);
        if (held) begin
          chk(res_valid && res_data == h_data && res_tag == h_tag, "R10",
              res_data, h_data);
        end
        held = 1'b0;
        if (res_valid && !res_ready) begin
          held   = 1'b1;
          h_data = res_data;
          h_tag  = res_tag;
        end
        if (res_valid && res_ready) begin
          if (q.size() == 0) begin
            chk(1'b0, "R9", {27'b0, res_tag}, 32'hFFFF_FFFF);
          end else begin
            exp_t e;
            e = q.pop_front();
            chk(res_tag == e.tag, "R9", {27'b0, res_tag}, {27'b0, e.tag});
            chk(res_data == e.data, e.is_div ? "R3" : "R2", res_data, e.data);
            chk(res_dz == e.dz, "R7", {31'b0, res_dz}, {31'b0, e.dz});
            if (lat_mode) begin
              chk((cyc - e.acc) == (e.is_div ? 34 : 3), e.is_div ? "R3" : "R2",
                  32'(cyc - e.acc), e.is_div ? 32'd34 : 32'd3);
            end
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 32'(cyc), 32'd0);
    finish_run();
  end

  initial begin
    int st;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11 reset state
    chk(res_valid == 1'b0, "R11", {31'b0, res_valid}, 32'd0);
    chk(dz_flag == 1'b0, "R11", {31'b0, dz_flag}, 32'd0);
    chk(iss_ready == 1'b1, "R11", {31'b0, iss_ready}, 32'd1);
    iss_op = 2'b10;
    #1;
    chk(iss_ready == 1'b1, "R11", {31'b0, iss_ready}, 32'd1);

    // R1/R2: back-to-back multiplies of both kinds
    for (int k = 0; k < 6; k++) begin
      issue(k[0] ? 2'b01 : 2'b00, pick(), pick(), st);
      chk(st == 0, "R1", 32'(st), 32'd0);
    end
    idle(6);

    // R3 signed divide, then R5 multiply held behind it
    issue(2'b10, 32'hFFFF_FFF9, 32'd2, st);
    issue(2'b01, 32'd12345, 32'd678, st);
    chk(st == 34, "R5", 32'(st), 32'd34);
    idle(5);

    // R5: divide right behind a divide
    issue(2'b11, 32'hFFFF_FFFF, 32'd3, st);
    issue(2'b10, 32'd100, 32'hFFFF_FFFD, st);
    chk(st == 34, "R5", 32'(st), 32'd34);
    idle(40);

    // R4: divide right behind a multiply waits for the pipeline to drain
    issue(2'b00, 32'hDEAD_BEEF, 32'h1234_5678, st);
    issue(2'b11, 32'd100, 32'd7, st);
    chk(st == 3, "R4", 32'(st), 32'd3);

    // R6: operand-free cycles during a divide never stall
    idle(40);

    // R7 divide by zero, both signednesses
    chk(dz_flag == 1'b0, "R8", {31'b0, dz_flag}, 32'd0);
    issue(2'b11, 32'd77, 32'd0, st);
    idle(40);
    chk(dz_flag == 1'b1, "R8", {31'b0, dz_flag}, 32'd1);
    issue(2'b10, 32'h8000_0000, 32'd0, st);
    idle(40);

    // R12 most-negative over minus one
    issue(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, st);
    idle(40);

    // Random phase with output back-pressure (R9, R10)
    lat_mode = 1'b0;
    bp_mode  = 1'b1;
    for (int k = 0; k < 250; k++) begin
      issue(2'($urandom % 4), pick(), pick(), st);
      if (($urandom % 4) == 0) idle(1 + int'($urandom % 3));
    end
    idle(2);
    bp_mode = 1'b0;
    for (int k = 0; k < 3000 && q.size() > 0; k++) @(negedge clk);
    chk(q.size() == 0, "R9", 32'(q.size()), 32'd0);
    #1;
    chk(res_valid == 1'b0, "R9", {31'b0, res_valid}, 32'd0);
    chk(dz_flag == 1'b1, "R8", {31'b0, dz_flag}, 32'd1);
    finish_run();
  end

endmodule